// File: doc/BRIEF.md
# Console I/O Register Bank

This block is the byte-wide register page that sits between a processor bus and the timer, sound, video and copy engines of a handheld console. It decodes an 8-bit offset and holds the page's control bytes. On a read it ORs each register's fixed bit mask into the stored value, so bits with no storage read as one. An offset with no register returns 0xFF. A few writes are bent by rules of their own: the interrupt flag byte always holds ones in its top three bits, and the sound master byte takes only its enable bit from the bus. Channel registers store zero while the sound master is off. The speed byte takes only its request bit from the bus.

Some writes reach the engines as one-cycle strobes: divider clear, interrupt re-evaluation and a block-copy start with its 16-bit source address. The divider count itself comes in from the timer and reads back through the page. A model-select pin turns on two extended registers. A flavour pin lets the older hardware keep two channel length registers writable while sound is off.

The bus is a plain register port, not a stream. Every access completes in the cycle it is presented, so there is no back-pressure and no ready signal. Read data is combinational from the address and shows the contents before any write in the same cycle.

Top module: `io_regfile`

## Requirements
- R1: A read of a defined register returns the stored byte ORed with that register's mask: 0xE0 for the interrupt flag (offset 0x00) and interrupt enable (0x01), 0xF8 for timer control (0x03), 0x7E for serial control (0x04), 0x70 for sound master (0x05), 0x7E for speed (0x0C), 0xFE for memory bank (0x0D), and 0x00 for LCD control (0x08), background palette (0x09), copy source (0x0A) and the sound channel bytes (0x10 to 0x1F).
- R2: With rd_en high, any offset not listed in R1 or R4 reads 0xFF. With rd_en low, rd_data is 0x00. A write to an unknown offset changes no readable value.
- R3: A write to offset 0x00 stores the data with bits 7:5 forced to one. A write to 0x00 or 0x01 raises irq_upd.
- R4: A write to offset 0x02 stores nothing and raises div_clr. A read of 0x02 returns the tmr_div input unchanged.
- R5: While snd_on is low, a write to a sound channel byte (0x10 to 0x1F) stores 0x00. The exception is legacy_snd high, where the bytes at 0x16 and 0x1C store the data.
- R6: A write to offset 0x05 sets the stored bit 7 from data bit 7 and keeps stored bits 3:0. snd_on equals stored bit 7.
- R7: After reset, the registers read: 0x00 as 0xE1, 0x01 as 0xE0, 0x05 as 0xF1, 0x08 as 0xC1, 0x09 as 0xFC, and every other stored register as its mask alone.
- R8: A write of value v to offset 0x0A raises dma_go and loads dma_src with {v, 8'h00}. dma_src holds until the next such write.
- R9: A write to offset 0x0C takes bit 0 from the data and keeps the stored bit 7.
- R10: With ext_en low, offsets 0x0C and 0x0D read 0xFF and writes to them are dropped.
- R11: Each strobe (div_clr, irq_upd, dma_go) is high for exactly the one cycle after the clock edge that takes the write, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Enables the extended registers (speed, memory bank) |
| legacy_snd | input | 1 | Older sound flavour: two length bytes stay writable while sound is off |
| addr | input | 8 | Register offset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read enable |
| rd_data | output | 8 | Read data, valid in the same cycle |
| tmr_div | input | 8 | Divider count from the timer, read through offset 0x02 |
| snd_on | output | 1 | Sound master enable as stored |
| div_clr | output | 1 | Divider clear pulse |
| irq_upd | output | 1 | Interrupt re-evaluation pulse |
| dma_go | output | 1 | Block-copy start pulse |
| dma_src | output | 16 | Block-copy source address |

## Verification
The assertions check on every cycle that the strobes follow their writes by exactly one edge, that the copy source is the written byte shifted up by eight, that the interrupt flag always reads ones in bits 7:5, and that unknown or disabled offsets read 0xFF. snd_on is checked to track the written enable bit. The storage rules need a write followed by a read of the same offset, and only the bench scenarios can show them: zeroing while sound is off, the legacy length exception, the merge rules and the reset values. The bench model covers those.

// File: rtl/io_pkg.sv
package io_pkg;
  // Bus offsets; the sound channel window is a parameter of the top.
  localparam logic [7:0] OFF_IFLG  = 8'h00;
  localparam logic [7:0] OFF_IENA  = 8'h01;
  localparam logic [7:0] OFF_DIV   = 8'h02;
  localparam logic [7:0] OFF_TCTL  = 8'h03;
  localparam logic [7:0] OFF_SCTL  = 8'h04;
  localparam logic [7:0] OFF_SMAS  = 8'h05;
  localparam logic [7:0] OFF_LCTL  = 8'h08;
  localparam logic [7:0] OFF_BGPAL = 8'h09;
  localparam logic [7:0] OFF_COPY  = 8'h0A;
  localparam logic [7:0] OFF_SPD   = 8'h0C;
  localparam logic [7:0] OFF_BANK  = 8'h0D;

  // Storage slot numbers
  localparam int SL_IFLG  = 0;
  localparam int SL_IENA  = 1;
  localparam int SL_TCTL  = 2;
  localparam int SL_SCTL  = 3;
  localparam int SL_SMAS  = 4;
  localparam int SL_LCTL  = 5;
  localparam int SL_BGPAL = 6;
  localparam int SL_COPY  = 7;
  localparam int SL_SPD   = 8;
  localparam int SL_BANK  = 9;
  localparam int SL_SND0  = 10;

  function automatic logic [7:0] mask_of(input int s);
    case (s)
      SL_IFLG, SL_IENA: return 8'hE0;
      SL_TCTL:          return 8'hF8;
      SL_SCTL, SL_SPD:  return 8'h7E;
      SL_SMAS:          return 8'h70;
      SL_BANK:          return 8'hFE;
      default:          return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reset_of(input int s);
    case (s)
      SL_IFLG:  return 8'h01;
      SL_SMAS:  return 8'hF1;
      SL_LCTL:  return 8'hC1;
      SL_BGPAL: return 8'hFC;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/io_decode.sv
module io_decode #(
  parameter int SND_BASE = 16,
  parameter int SND_N    = 16,
  parameter int SLOT_W   = 5
) (
  input  logic [7:0]        addr,
  input  logic              ext_en,
  output logic              hit,
  output logic              div_hit,
  output logic [SLOT_W-1:0] slot
);
  import io_pkg::*;

  always_comb begin
    hit     = 1'b1;
    div_hit = 1'b0;
    slot    = '0;
    case (addr)
      OFF_IFLG:  slot = SLOT_W'(SL_IFLG);
      OFF_IENA:  slot = SLOT_W'(SL_IENA);
      OFF_TCTL:  slot = SLOT_W'(SL_TCTL);
      OFF_SCTL:  slot = SLOT_W'(SL_SCTL);
      OFF_SMAS:  slot = SLOT_W'(SL_SMAS);
      OFF_LCTL:  slot = SLOT_W'(SL_LCTL);
      OFF_BGPAL: slot = SLOT_W'(SL_BGPAL);
      OFF_COPY:  slot = SLOT_W'(SL_COPY);
      OFF_DIV: begin
        hit     = 1'b0;
        div_hit = 1'b1;
      end
      OFF_SPD: begin
        hit  = ext_en;
        slot = SLOT_W'(SL_SPD);
      end
      OFF_BANK: begin
        hit  = ext_en;
        slot = SLOT_W'(SL_BANK);
      end
      default: begin
        if (int'(addr) >= SND_BASE && int'(addr) < SND_BASE + SND_N)
          slot = SLOT_W'(int'(addr) - SND_BASE + SL_SND0);
        else
          hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/io_store.sv
module io_store #(
  parameter int NSLOT    = 26,
  parameter int SLOT_W   = 5,
  parameter int LEN3_IDX = 6,
  parameter int LEN4_IDX = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SLOT_W-1:0]     slot,
  input  logic [7:0]            wdata,
  input  logic                  legacy_snd,
  output logic [NSLOT-1:0][7:0] q,
  output logic                  snd_on
);
  import io_pkg::*;

  assign snd_on = q[SL_SMAS][7];

  for (genvar g = 0; g < NSLOT; g++) begin : g_reg
    localparam logic [7:0] RV = reset_of(g);
    logic [7:0] r;
    logic [7:0] nxt;
    logic       sel;

    assign sel  = we && (slot == SLOT_W'(g));
    assign q[g] = r;

    if (g == SL_IFLG) begin : g_iflg
      assign nxt = wdata | 8'hE0;
    end else if (g == SL_SMAS) begin : g_smas
      assign nxt = {wdata[7], 3'b000, r[3:0]};
    end else if (g == SL_SPD) begin : g_spd
      assign nxt = {r[7], 6'b000000, wdata[0]};
    end else if (g >= SL_SND0) begin : g_snd
      localparam bit KEEP = ((g - SL_SND0) == LEN3_IDX) || ((g - SL_SND0) == LEN4_IDX);
      assign nxt = (snd_on || (legacy_snd && KEEP)) ? wdata : 8'h00;
    end else begin : g_plain
      assign nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r <= RV;
      else if (sel) r <= nxt;
    end
  end
endmodule

// File: rtl/io_rdmux.sv
module io_rdmux #(
  parameter int NSLOT  = 26,
  parameter int SLOT_W = 5
) (
  input  logic                  rd_en,
  input  logic                  hit,
  input  logic                  div_hit,
  input  logic [SLOT_W-1:0]     slot,
  input  logic [NSLOT-1:0][7:0] q,
  input  logic [7:0]            tmr_div,
  output logic [7:0]            rd_data
);
  import io_pkg::*;

  always_comb begin
    if (!rd_en)       rd_data = 8'h00;
    else if (div_hit) rd_data = tmr_div;
    else if (hit)     rd_data = q[slot] | mask_of(int'(slot));
    else              rd_data = 8'hFF;
  end
endmodule

// File: rtl/io_regfile.sv
module io_regfile #(
  parameter int SND_BASE = 16,
  parameter int SND_N    = 16,
  parameter int LEN3_IDX = 6,
  parameter int LEN4_IDX = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_en,
  input  logic        legacy_snd,
  input  logic [7:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  input  logic [7:0]  tmr_div,
  output logic        snd_on,
  output logic        div_clr,
  output logic        irq_upd,
  output logic        dma_go,
  output logic [15:0] dma_src
);
  import io_pkg::*;

  localparam int NSLOT  = SL_SND0 + SND_N;
  localparam int SLOT_W = $clog2(NSLOT);

  logic                  hit;
  logic                  div_hit;
  logic [SLOT_W-1:0]     slot;
  logic [NSLOT-1:0][7:0] q;
  logic                  we;

  assign we = wr_en && hit;

  io_decode #(.SND_BASE(SND_BASE), .SND_N(SND_N), .SLOT_W(SLOT_W)) u_dec (
    .addr(addr), .ext_en(ext_en), .hit(hit), .div_hit(div_hit), .slot(slot)
  );

  io_store #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .LEN3_IDX(LEN3_IDX), .LEN4_IDX(LEN4_IDX)) u_st (
    .clk(clk), .rst_n(rst_n), .we(we), .slot(slot), .wdata(wr_data),
    .legacy_snd(legacy_snd), .q(q), .snd_on(snd_on)
  );

  io_rdmux #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_rd (
    .rd_en(rd_en), .hit(hit), .div_hit(div_hit), .slot(slot), .q(q),
    .tmr_div(tmr_div), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_clr <= 1'b0;
      irq_upd <= 1'b0;
      dma_go  <= 1'b0;
      dma_src <= 16'h0000;
    end else begin
      div_clr <= wr_en && div_hit;
      irq_upd <= we && (slot == SLOT_W'(SL_IFLG) || slot == SLOT_W'(SL_IENA));
      dma_go  <= we && (slot == SLOT_W'(SL_COPY));
      if (we && slot == SLOT_W'(SL_COPY)) dma_src <= {wr_data, 8'h00};
    end
  end
endmodule

// File: rtl/io_regfile_chk.sv
module io_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_en,
  input logic [7:0]  addr,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic        rd_en,
  input logic [7:0]  rd_data,
  input logic        snd_on,
  input logic        div_clr,
  input logic        irq_upd,
  input logic        dma_go,
  input logic [15:0] dma_src
);
  import io_pkg::*;

  // R1 / R3: flag byte always reads ones in its top bits
  p_iflg_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_IFLG) |-> (rd_data[7:5] == 3'b111));

  // R2: a hole in the map reads all ones
  p_hole_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 8'h06 || addr == 8'hFF)) |-> (rd_data == 8'hFF));

  // R10: extended offsets vanish when disabled
  p_ext_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ext_en && (addr == OFF_SPD || addr == OFF_BANK)) |-> (rd_data == 8'hFF));

  // R3
  p_irq_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFF_IFLG || addr == OFF_IENA)) |=> irq_upd);

  // R4
  p_div_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_DIV) |=> div_clr);

  // R8
  p_copy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_COPY) |=> (dma_go && dma_src == {$past(wr_data), 8'h00}));

  // R6
  p_master_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_SMAS) |=> (snd_on == $past(wr_data[7])));

  // R11: no strobe without a write on the previous edge
  p_div_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFF_DIV) |=> !div_clr);
  p_copy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFF_COPY) |=> !dma_go);
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div_clr, irq_upd, dma_go}));
endmodule

bind io_regfile io_regfile_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .snd_on(snd_on),
  .div_clr(div_clr), .irq_upd(irq_upd), .dma_go(dma_go), .dma_src(dma_src)
);

// File: tb/test_io_regfile.sv
module test_io_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b1;
  logic        legacy_snd = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [7:0]  tmr_div = 8'h5A;
  logic        snd_on, div_clr, irq_upd, dma_go;
  logic [15:0] dma_src;

  always #5 clk = ~clk;

  io_regfile i_io_regfile (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .legacy_snd(legacy_snd),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .tmr_div(tmr_div), .snd_on(snd_on), .div_clr(div_clr),
    .irq_upd(irq_upd), .dma_go(dma_go), .dma_src(dma_src)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Behavioural model: byte per bus offset
  logic [7:0]  m [0:255];
  logic        e_div, e_irq, e_go;
  logic [15:0] e_src;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h02) return "R4";
    if (a == 8'h0C) return "R9";
    if (a == 8'h0D) return "R10";
    if (a >= 8'h10 && a <= 8'h1F) return "R5";
    if (a == 8'h05) return "R6";
    return "R1";
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] a, input logic r);
    if (!r) return 8'h00;
    case (a)
      8'h00, 8'h01: return m[a] | 8'hE0;
      8'h02: return tmr_div;
      8'h03: return m[a] | 8'hF8;
      8'h04: return m[a] | 8'h7E;
      8'h05: return m[a] | 8'h70;
      8'h08, 8'h09, 8'h0A: return m[a];
      8'h0C: return ext_en ? (m[a] | 8'h7E) : 8'hFF;
      8'h0D: return ext_en ? (m[a] | 8'hFE) : 8'hFF;
      default: return (a >= 8'h10 && a <= 8'h1F) ? m[a] : 8'hFF;
    endcase
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    e_div = (a == 8'h02);
    e_irq = (a == 8'h00 || a == 8'h01);
    e_go  = (a == 8'h0A);
    if (e_go) e_src = {d, 8'h00};
    case (a)
      8'h00: m[a] = d | 8'hE0;
      8'h01, 8'h03, 8'h04, 8'h08, 8'h09, 8'h0A: m[a] = d;
      8'h05: m[a] = {d[7], 3'b000, m[a][3:0]};
      8'h0C: if (ext_en) m[a] = {m[a][7], 6'd0, d[0]};
      8'h0D: if (ext_en) m[a] = d;
      default:
        if (a >= 8'h10 && a <= 8'h1F) begin
          if (m[8'h05][7] || (legacy_snd && (a == 8'h16 || a == 8'h1C))) m[a] = d;
          else m[a] = 8'h00;
        end
    endcase
  endtask

  // One bus cycle; entered and left at a falling edge
  task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_en = w; rd_en = r; wr_data = d;
    #1;
    chk(rd_data, mread(a, r), r ? tag_of(a) : "R2");
    chk(snd_on, m[8'h05][7], "R6");
    @(posedge clk); #1;
    e_div = 0; e_irq = 0; e_go = 0;
    if (w) mwrite(a, d);
    @(negedge clk);
    chk(div_clr, e_div, "R11 R4");
    chk(irq_upd, e_irq, "R11 R3");
    chk(dma_go, e_go, "R11 R8");
    chk(dma_src, e_src, "R8");
    wr_en = 0; rd_en = 0;
  endtask

  task automatic rd(input logic [7:0] a); cyc(0, 1, a, 8'h00); endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d); cyc(1, 0, a, d); endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    m[8'h00] = 8'h01; m[8'h05] = 8'hF1; m[8'h08] = 8'hC1; m[8'h09] = 8'hFC;
    e_src = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset values, R1 masks, R2 holes
    chk(rd_data, 8'h00, "R2 rd_en low");
    for (int a = 0; a < 48; a++) rd(8'(a));
    chk({24'd0, mread(8'h00, 1)}, 32'hE1, "R7 flag reset");
    // R3 flag write forces top bits, enable plain
    wr(8'h00, 8'h00); rd(8'h00);
    wr(8'h00, 8'h1F); rd(8'h00);
    wr(8'h01, 8'hFF); rd(8'h01);
    // R4 divider
    wr(8'h02, 8'h77); tmr_div = 8'h3C; rd(8'h02);
    // R5 with sound on, R6 master merge
    wr(8'h12, 8'hAB); rd(8'h12);
    wr(8'h05, 8'h0F); rd(8'h05);
    wr(8'h12, 8'h55); rd(8'h12);
    wr(8'h16, 8'h44); rd(8'h16);
    legacy_snd = 1'b1;
    wr(8'h16, 8'h77); rd(8'h16);
    wr(8'h1C, 8'h99); rd(8'h1C);
    wr(8'h13, 8'h21); rd(8'h13);
    legacy_snd = 1'b0;
    wr(8'h05, 8'h80); rd(8'h05);
    wr(8'h13, 8'h21); rd(8'h13);
    // R8 copy start
    wr(8'h0A, 8'hC3); rd(8'h0A); rd(8'h00);
    // R9 speed merge
    wr(8'h0C, 8'hFF); rd(8'h0C);
    wr(8'h0C, 8'h80); rd(8'h0C);
    // R10 extended gating
    wr(8'h0D, 8'h01); rd(8'h0D);
    ext_en = 1'b0;
    rd(8'h0C); rd(8'h0D);
    wr(8'h0D, 8'h00);
    ext_en = 1'b1;
    rd(8'h0D);
    // R2 unknown write ignored, rd_en low
    wr(8'h06, 8'h12); rd(8'h06);
    cyc(0, 0, 8'h09, 8'h00);
    // same-cycle read and write shows old value
    cyc(1, 1, 8'h09, 8'h3A); rd(8'h09);
    cyc(1, 1, 8'h03, 8'h05); rd(8'h03); rd(8'h04);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule